// File: doc/BRIEF.md
# Fast Ethernet PMD Symbol Datapath

This block is the digital core of a 100 Mb/s copper media transceiver. The analog front end is modelled as logic signals. On the transmit side it samples a 5-bit symbol once per 25 MHz period and shifts it out one bit per cycle of a 125 MHz clock. It converts the bit stream to NRZI and drives a three-level MLT-3 line code, given as a 2-bit level plus separate enables for the 100 Mb/s and 10 Mb/s line drivers.

On the receive side two window-comparator flags, one for a level above the positive threshold and one for a level below the negative threshold, are combined to give the NRZI line bit. That bit is decoded to NRZ and collected into a serial-to-parallel register. The assembled symbol is latched and presented on a 5-bit bus, together with a receive clock that is the 125 MHz clock divided by five. There is no symbol alignment. The frame boundary comes from a divide-by-5 phase counter that starts at phase 0 after a synchronous reset.

Control inputs cover four functions. A loopback mode sends the NRZI transmit stream back into the receive path, forces signal-detect true and mutes the 100 Mb/s driver. An output-enable gates both drivers, and a 10/100 selector picks one of them. An undervoltage flag shuts both drivers off.

Top module: `fepmd_symbol_path`

## Requirements
- R1: After reset is released, the first cycle is phase 0 of a 5-cycle frame and the phase then counts 0,1,2,3,4 and wraps. `rxClk` is 1 in phases 0 and 1 and 0 in phases 2, 3 and 4.
- R2: `txSym` is sampled at the clock edge that ends phase 4. In the next frame its bit p is the serial transmit bit during phase p, so bit 0 goes first. Before the first sample the serial bit is 0.
- R3: The MLT-3 encoder advances one step at each edge whose serial bit was 1 and holds its level when that bit was 0. The steps cycle through zero, positive, zero, negative, starting from zero after reset. `lineLvl` codes zero as 2'b00, positive as 2'b01 and negative as 2'b11. The level never moves directly between positive and negative.
- R4: The receive line bit is `cmpPos | cmpNeg`, registered once. The decoded bit during a cycle is the XOR of the last two registered line bits. `rxSym` bit i is the decoded bit during phase i of a frame. It is latched at the edge that ends phase 4 and holds for the rest of the next frame.
- R5: With `loopEn` = 1 the comparators are ignored and the NRZI transmit stream is the receive line bit. If one symbol S is sent repeatedly, `rxSym` settles to S rotated so that `rxSym[i]` = S[(i+3) mod 5].
- R6: `sigDet` is 1 whenever `loopEn` = 1; otherwise it equals `sigDetIn`.
- R7: When `txOutEn` = 0, both `drvEn100` and `drvEn10` are 0 whatever `sel100` is.
- R8: With `txOutEn` = 1 and no undervoltage, `sel100` = 0 enables only `drvEn10`. `sel100` = 1 enables only `drvEn100`, unless loopback mutes it.
- R9: When `underVolt` = 1, both driver enables are 0.
- R10: Loopback forces `drvEn100` to 0 and leaves `drvEn10` unaffected.
- R11: During reset and in cycle 0 after it, `rxSym` = 0, `lineLvl` = 2'b00 and `rxClk` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz bit clock |
| rst | input | 1 | Synchronous active-high reset |
| txSym | input | 5 | Transmit symbol from the coding layer |
| txOutEn | input | 1 | Transmit driver output enable |
| sel100 | input | 1 | 1 selects the 100 Mb/s driver, 0 the 10 Mb/s driver |
| loopEn | input | 1 | Internal loopback enable |
| underVolt | input | 1 | Supply undervoltage flag |
| lineLvl | output | 2 | MLT-3 level code (00 zero, 01 positive, 11 negative) |
| drvEn100 | output | 1 | 100 Mb/s driver enable (0 means tristate) |
| drvEn10 | output | 1 | 10 Mb/s driver enable (0 means tristate) |
| cmpPos | input | 1 | Receive level above the positive threshold |
| cmpNeg | input | 1 | Receive level below the negative threshold |
| sigDetIn | input | 1 | Amplitude detector from the analog front end |
| sigDet | output | 1 | Signal-detect output |
| rxSym | output | 5 | Received symbol, latched once per frame |
| rxClk | output | 1 | Receive symbol clock, bit clock divided by five |

## Verification
The properties assume a single clock and a synchronous reset held for at least one edge. They place no restriction on the comparator, enable or symbol inputs, because every driver and signal-detect relation must hold for any combination. The bench always drives `cmpPos` and `cmpNeg` so that both are never 1 together, which matches a physical line. It changes inputs only a short time after a rising edge, so every latched value has a defined sample cycle. Symbol sweeps run at frame rate through all 32 codes in both the direct and loopback paths. The control inputs are swept through all 32 combinations.

// File: rtl/fepmd_pkg.sv
package fepmd_pkg;

  // MLT-3 line level codes
  localparam logic [1:0] LVL_ZERO = 2'b00;
  localparam logic [1:0] LVL_POS  = 2'b01;
  localparam logic [1:0] LVL_NEG  = 2'b11;

  // Per-frame strobes from control to datapath
  typedef struct packed {
    logic loadSym;   // capture txSym into the serializer
    logic latchRx;   // copy assembled receive symbol to rxSym
  } strobes_t;

endpackage

// File: rtl/fepmd_ctrl.sv
module fepmd_ctrl
  import fepmd_pkg::*;
#(
  parameter int SYM_W = 5
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     txOutEn,
  input  logic     sel100,
  input  logic     loopEn,
  input  logic     underVolt,
  input  logic     sigDetIn,
  output strobes_t strb,
  output logic     rxClk,
  output logic     drvEn100,
  output logic     drvEn10,
  output logic     sigDet
);

  localparam int PH_W = (SYM_W > 1) ? $clog2(SYM_W) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SYM_W - 1);
  localparam logic [PH_W-1:0] HI_CNT  = PH_W'(SYM_W / 2);

  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] phNext;
  logic            rxClkQ;

  assign phNext = (phase == PH_LAST) ? '0 : phase + 1'b1;

  // Phase counter and divided receive clock (high for the first phases)
  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= '0;
      rxClkQ <= 1'b1;
    end else begin
      phase  <= phNext;
      rxClkQ <= (phNext < HI_CNT);
    end
  end

  always_comb begin
    strb.loadSym = (phase == PH_LAST);
    strb.latchRx = (phase == PH_LAST);
  end

  assign rxClk = rxClkQ;

  // Driver gating: enable and undervoltage dominate, loopback mutes 100 only
  assign drvEn100 = txOutEn & ~underVolt & sel100 & ~loopEn;
  assign drvEn10  = txOutEn & ~underVolt & ~sel100;
  assign sigDet   = loopEn | sigDetIn;

endmodule

// File: rtl/fepmd_datapath.sv
module fepmd_datapath
  import fepmd_pkg::*;
#(
  parameter int SYM_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  strobes_t         strb,
  input  logic [SYM_W-1:0] txSym,
  input  logic             cmpPos,
  input  logic             cmpNeg,
  input  logic             loopEn,
  output logic [1:0]       lineLvl,
  output logic [SYM_W-1:0] rxSym
);

  // ---------------- transmit ----------------
  logic [SYM_W-1:0] txSr;
  logic             serBit;
  logic             txNrzi;
  logic [1:0]       mltStep;

  assign serBit = txSr[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      txSr    <= '0;
      txNrzi  <= 1'b0;
      mltStep <= 2'd0;
    end else begin
      txSr    <= strb.loadSym ? txSym : (txSr >> 1);
      txNrzi  <= txNrzi ^ serBit;
      mltStep <= mltStep + {1'b0, serBit};
    end
  end

  always_comb begin
    case (mltStep)
      2'd1:    lineLvl = LVL_POS;
      2'd3:    lineLvl = LVL_NEG;
      default: lineLvl = LVL_ZERO;
    endcase
  end

  // ---------------- receive ----------------
  logic             lineIn;
  logic             rxNrziQ;
  logic             rxPrevQ;
  logic             nrzBit;
  logic [SYM_W-2:0] rxSr;
  logic [SYM_W-1:0] rxAsm;

  assign lineIn = loopEn ? txNrzi : (cmpPos | cmpNeg);
  assign nrzBit = rxNrziQ ^ rxPrevQ;
  assign rxAsm  = {nrzBit, rxSr};

  always_ff @(posedge clk) begin
    if (rst) begin
      rxNrziQ <= 1'b0;
      rxPrevQ <= 1'b0;
      rxSr    <= '0;
      rxSym   <= '0;
    end else begin
      rxNrziQ <= lineIn;
      rxPrevQ <= rxNrziQ;
      rxSr    <= rxAsm[SYM_W-1:1];
      if (strb.latchRx) rxSym <= rxAsm;
    end
  end

endmodule

// File: rtl/fepmd_symbol_path.sv
module fepmd_symbol_path
  import fepmd_pkg::*;
#(
  parameter int SYM_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SYM_W-1:0] txSym,
  input  logic             txOutEn,
  input  logic             sel100,
  input  logic             loopEn,
  input  logic             underVolt,
  output logic [1:0]       lineLvl,
  output logic             drvEn100,
  output logic             drvEn10,
  input  logic             cmpPos,
  input  logic             cmpNeg,
  input  logic             sigDetIn,
  output logic             sigDet,
  output logic [SYM_W-1:0] rxSym,
  output logic             rxClk
);

  strobes_t strb;

  fepmd_ctrl #(.SYM_W(SYM_W)) u_ctrl (
    .clk(clk), .rst(rst), .txOutEn(txOutEn), .sel100(sel100),
    .loopEn(loopEn), .underVolt(underVolt), .sigDetIn(sigDetIn),
    .strb(strb), .rxClk(rxClk), .drvEn100(drvEn100),
    .drvEn10(drvEn10), .sigDet(sigDet)
  );

  fepmd_datapath #(.SYM_W(SYM_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .txSym(txSym),
    .cmpPos(cmpPos), .cmpNeg(cmpNeg), .loopEn(loopEn),
    .lineLvl(lineLvl), .rxSym(rxSym)
  );

endmodule

// File: rtl/fepmd_checker.sv
module fepmd_checker
  import fepmd_pkg::*;
#(
  parameter int SYM_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             txOutEn,
  input logic             sel100,
  input logic             loopEn,
  input logic             underVolt,
  input logic [1:0]       lineLvl,
  input logic             drvEn100,
  input logic             drvEn10,
  input logic             sigDetIn,
  input logic             sigDet,
  input logic [SYM_W-1:0] rxSym,
  input logic             rxClk
);

  a_r1_clk_high_two: assert property (@(posedge clk) disable iff (rst)
    $rose(rxClk) |=> rxClk);

  a_r1_clk_low_three: assert property (@(posedge clk) disable iff (rst)
    $fell(rxClk) |=> !rxClk);

  a_r3_legal_code: assert property (@(posedge clk) disable iff (rst)
    lineLvl != 2'b10);

  a_r3_no_pos_to_neg: assert property (@(posedge clk) disable iff (rst)
    ($past(lineLvl) == LVL_POS) |-> (lineLvl != LVL_NEG));

  a_r3_no_neg_to_pos: assert property (@(posedge clk) disable iff (rst)
    ($past(lineLvl) == LVL_NEG) |-> (lineLvl != LVL_POS));

  a_r4_rx_hold: assert property (@(posedge clk) disable iff (rst)
    !$rose(rxClk) |-> $stable(rxSym));

  a_r6_loop_sigdet: assert property (@(posedge clk) disable iff (rst)
    loopEn |-> sigDet);

  a_r6_follow_sigdet: assert property (@(posedge clk) disable iff (rst)
    !loopEn |-> (sigDet == sigDetIn));

  a_r7_oe_tristate: assert property (@(posedge clk) disable iff (rst)
    !txOutEn |-> (!drvEn100 && !drvEn10));

  a_r8_one_driver: assert property (@(posedge clk) disable iff (rst)
    !(drvEn100 && drvEn10));

  a_r8_sel10: assert property (@(posedge clk) disable iff (rst)
    (txOutEn && !underVolt && !sel100) |-> drvEn10);

  a_r9_uv_off: assert property (@(posedge clk) disable iff (rst)
    underVolt |-> (!drvEn100 && !drvEn10));

  a_r10_loop_mute: assert property (@(posedge clk) disable iff (rst)
    loopEn |-> !drvEn100);

endmodule

bind fepmd_symbol_path fepmd_checker #(.SYM_W(SYM_W)) u_chk (.*);

// File: tb/fepmd_symbol_path_bench.sv
`timescale 1ns/1ps
module fepmd_symbol_path_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic [4:0] txSym;
  logic       txOutEn, sel100, loopEn, underVolt;
  logic [1:0] lineLvl;
  logic       drvEn100, drvEn10;
  logic       cmpPos, cmpNeg, sigDetIn, sigDet;
  logic [4:0] rxSym;
  logic       rxClk;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fepmd_symbol_path u_fepmd_symbol_path (
    .clk(clk), .rst(rst), .txSym(txSym), .txOutEn(txOutEn), .sel100(sel100),
    .loopEn(loopEn), .underVolt(underVolt), .lineLvl(lineLvl),
    .drvEn100(drvEn100), .drvEn10(drvEn10), .cmpPos(cmpPos), .cmpNeg(cmpNeg),
    .sigDetIn(sigDetIn), .sigDet(sigDet), .rxSym(rxSym), .rxClk(rxClk)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic int txPat(int f);  return (f * 11 + 5) % 32; endfunction
  function automatic int rxPat(int f);  return (f * 7 + 3) % 32;  endfunction
  function automatic int lvlOf(int m);
    case (m % 4)
      1: return 1;
      3: return 3;
      default: return 0;
    endcase
  endfunction
  function automatic int rot3(int s); return ((s >> 3) | (s << 2)) & 31; endfunction

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int mState;
    int lineSt;
    rst = 1'b1; txSym = '0; txOutEn = 1'b1; sel100 = 1'b1; loopEn = 1'b0;
    underVolt = 1'b0; cmpPos = 1'b0; cmpNeg = 1'b0; sigDetIn = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R11: state held in reset
    chk("R11 rxSym in reset", rxSym, 0);
    chk("R11 lineLvl in reset", lineLvl, 0);
    @(negedge clk);
    rst = 1'b0;
    // R11: cycle 0 after release
    chk("R11 rxSym cycle0", rxSym, 0);
    chk("R11 lineLvl cycle0", lineLvl, 0);
    chk("R11 rxClk cycle0", rxClk, 1);

    // Direct path: transmit and receive sweeps run together
    mState = 0;
    lineSt = 0;
    for (int c = 0; c < 35 * 5; c++) begin
      int frame, q, b, tf, rb;
      frame = c / 5;
      q = c % 5;
      txSym = 5'(txPat(frame));
      b = (frame >= 1) ? ((txPat(frame - 1) >> q) & 1) : 0;   // R2
      tf = (q == 4) ? frame + 1 : frame;
      rb = (rxPat(tf) >> ((q + 1) % 5)) & 1;
      lineSt = lineSt ^ rb;
      cmpPos = (lineSt == 1) && (tf % 2 == 0);
      cmpNeg = (lineSt == 1) && (tf % 2 == 1);
      chk("R1 rxClk phase", rxClk, (q < 2) ? 1 : 0);
      step();
      mState = mState + b;
      chk("R2/R3 lineLvl", lineLvl, lvlOf(mState));
      if (q == 4 && frame >= 1)
        chk("R4 rxSym direct", rxSym, rxPat(frame));
    end

    // R5: loopback with every symbol, comparators toggling and ignored
    loopEn = 1'b1;
    sigDetIn = 1'b0;
    for (int s = 0; s < 32; s++) begin
      txSym = 5'(s);
      for (int k = 0; k < 15; k++) begin
        cmpPos = k[0];
        cmpNeg = ~k[0];
        step();
      end
      chk("R5 rxSym loopback", rxSym, rot3(s));
      chk("R6 sigDet forced", sigDet, 1);
      chk("R10 drvEn100 muted", drvEn100, 0);
    end

    // R6..R10: exhaustive control combinations
    for (int v = 0; v < 32; v++) begin
      int oe, sl, uv, lp, sd;
      oe = v & 1; sl = (v >> 1) & 1; uv = (v >> 2) & 1;
      lp = (v >> 3) & 1; sd = (v >> 4) & 1;
      txOutEn = oe[0]; sel100 = sl[0]; underVolt = uv[0];
      loopEn = lp[0]; sigDetIn = sd[0];
      #1;
      chk("R7/R8/R9/R10 drvEn100", drvEn100, oe & sl & (1 - uv) & (1 - lp));
      chk("R7/R8/R9/R10 drvEn10", drvEn10, oe & (1 - sl) & (1 - uv));
      chk("R6 sigDet", sigDet, lp | sd);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule